// File: doc/BRIEF.md
# Base-Delta Cache Line Decompressor

This block turns a compressed cache-line image back into a full 64-byte line. The image opens with a 3-bit algorithm code. Seven of the eight codes name a base-plus-delta encoding, each with its own pair of word size and delta size. The line is cut into words of the base size. Each word is stored as a narrow signed delta. That delta is added either to one explicit base or to an implicit base of zero, and one mask bit per word makes the choice. Once the code is decoded, every field offset is a constant, so each encoding is expanded by fixed wiring and one adder per word.

The remaining code names the frequent-pattern encoding. This block does not expand it. It raises a pass-through flag so that a separate decoder, which sees the same input image, can take the line over. Images are presented with a valid strobe. A rebuilt line comes out with its own valid strobe two clock edges later. A new image can be accepted on every cycle.

Top module: `base_delta_decomp`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` and `fpc_pass` are 0 and `out_line` is all zeros until the first image arrives.
- R2: A valid image with a nonzero code sampled at clock edge N gives `out_valid` = 1 for exactly one cycle after edge N+2. No other cycle has `out_valid` high.
- R3: A valid image with code 0 (frequent-pattern) gives `fpc_pass` = 1 for one cycle after edge N+2. In that cycle `out_valid` stays 0 and `out_line` is unchanged.
- R4: The image is packed LSB-first in this order:
  - the code in bits [2:0];
  - then one mask bit per word, starting at bit 3;
  - then the base;
  - then the deltas in word order.
  Word 0 of the rebuilt line occupies its least significant bits.
- R5: Each output word is the selected base plus the delta sign-extended to the word width, taken modulo 2^(word width).
- R6: A mask bit of 0 selects a base of zero, so that word equals its sign-extended delta. A mask bit of 1 selects the explicit base.
- R7: Code 1 has delta size 0, so every word equals the explicit base or zero, as its mask bit selects.
- R8: The code table, as (base bytes, delta bytes), is: 1 = (8,0), 2 = (8,1), 3 = (8,2), 4 = (8,4), 5 = (4,1), 6 = (4,2), 7 = (2,1).
- R9: `out_line` holds its last value in every cycle where `out_valid` is 0.
- R10: Images presented on consecutive cycles are each rebuilt, in order, on consecutive cycles.
- R11: Input bits above the end of the selected encoding's image have no effect on the rebuilt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Image strobe |
| in_data | input | 331 | Compressed image, code in bits [2:0] |
| out_valid | output | 1 | Rebuilt line strobe |
| out_line | output | 512 | Rebuilt 64-byte line |
| fpc_pass | output | 1 | Image uses the frequent-pattern code and goes to the other decoder |

## Verification
The bench walks all seven base-delta codes and the pass-through code. It builds each image bit by bit and computes the expected line arithmetically.

It targets the following corner cases:
- **Sign extension.** Deltas at the largest positive and most negative value expose a decoder that zero-extends a delta or sign-extends from the wrong bit.
- **Wrap-around.** An all-ones base plus a delta of 1 catches an adder that carries past the word width into the next word.
- **Mask patterns.** All-zero, all-one and random masks catch a base select that is inverted or indexed to the wrong word.
- **Junk above the image.** Random bits above each encoding's image catch field offsets taken from the wrong variant.
- **Interleaving.** Back-to-back images, idle gaps and pass-through codes check that the strobes are neither lost nor doubled, and that the line register never moves without `out_valid`.

// File: rtl/bdl_pkg.sv
package bdl_pkg;

    localparam int LINE_BYTES = 64;
    localparam int LINE_BITS  = LINE_BYTES * 8;
    localparam int CODE_BITS  = 3;
    localparam int NUM_ALG    = 1 << CODE_BITS;

    typedef enum logic [CODE_BITS-1:0] {
        ALG_PATTERN = 3'd0,
        ALG_B8_D0   = 3'd1,
        ALG_B8_D1   = 3'd2,
        ALG_B8_D2   = 3'd3,
        ALG_B8_D4   = 3'd4,
        ALG_B4_D1   = 3'd5,
        ALG_B4_D2   = 3'd6,
        ALG_B2_D1   = 3'd7
    } alg_e;

    // Word (base) size in bytes for an algorithm code.
    function automatic int base_bytes(input int code);
        case (code)
            1, 2, 3, 4: return 8;
            5, 6:       return 4;
            7:          return 2;
            default:    return 8;
        endcase
    endfunction

    // Delta size in bytes for an algorithm code.
    function automatic int delta_bytes(input int code);
        case (code)
            2, 5, 7: return 1;
            3, 6:    return 2;
            4:       return 4;
            default: return 0;
        endcase
    endfunction

    // Total image length in bits: code, mask, base, deltas.
    function automatic int img_bits(input int code);
        int nw;
        nw = LINE_BYTES / base_bytes(code);
        return CODE_BITS + nw + base_bytes(code) * 8 + nw * delta_bytes(code) * 8;
    endfunction

    // Longest image over all base-delta codes sets the input width.
    function automatic int max_img_bits();
        int m;
        m = 0;
        for (int c = 1; c < NUM_ALG; c++) begin
            if (img_bits(c) > m) m = img_bits(c);
        end
        return m;
    endfunction

    localparam int IMG_BITS = max_img_bits();

endpackage

// File: rtl/bdl_variant.sv
// Combinational expander for one base-delta encoding. Input is the image
// body after the code bits: mask, then base, then deltas, LSB-first.
module bdl_variant #(
    parameter int BASE_B  = 8,
    parameter int DELTA_B = 1,
    parameter int LINE_B  = 64
) (
    input  logic [LINE_B/BASE_B + BASE_B*8 + (LINE_B/BASE_B)*DELTA_B*8 - 1:0] body,
    output logic [LINE_B*8-1:0] line
);
    localparam int WB       = BASE_B * 8;
    localparam int NW       = LINE_B / BASE_B;
    localparam int DW       = DELTA_B * 8;
    localparam int BASE_LSB = NW;
    localparam int DEL_LSB  = NW + WB;

    logic [WB-1:0] base_v;
    assign base_v = body[BASE_LSB +: WB];

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [WB-1:0] sel_base;
        assign sel_base = body[w] ? base_v : '0;
        if (DELTA_B == 0) begin : g_nodelta
            assign line[w*WB +: WB] = sel_base;
        end else begin : g_delta
            logic [DW-1:0] dlt;
            logic [WB-1:0] dlt_ext;
            assign dlt     = body[DEL_LSB + w*DW +: DW];
            assign dlt_ext = {{(WB-DW){dlt[DW-1]}}, dlt};
            assign line[w*WB +: WB] = sel_base + dlt_ext;
        end
    end
endmodule

// File: rtl/base_delta_decomp.sv
module base_delta_decomp (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [bdl_pkg::IMG_BITS-1:0] in_data,
    output logic                         out_valid,
    output logic [bdl_pkg::LINE_BITS-1:0] out_line,
    output logic                         fpc_pass
);
    import bdl_pkg::*;

    typedef struct packed {
        logic                vld;
        logic [IMG_BITS-1:0] img;
    } cap_t;

    typedef struct packed {
        logic                 vld;
        logic                 pass;
        logic [LINE_BITS-1:0] line;
    } res_t;

    cap_t cap_d, cap_q;
    res_t res_d, res_q;

    logic [CODE_BITS-1:0] code_q;
    logic [LINE_BITS-1:0] var_line [NUM_ALG];

    assign code_q = cap_q.img[CODE_BITS-1:0];

    // One expander per base-delta code; code 0 has no expander.
    for (genvar v = 0; v < NUM_ALG; v++) begin : g_alg
        if (v == 0) begin : g_pattern
            assign var_line[v] = '0;
        end else begin : g_bd
            localparam int IB = img_bits(v);
            bdl_variant #(
                .BASE_B (base_bytes(v)),
                .DELTA_B(delta_bytes(v)),
                .LINE_B (LINE_BYTES)
            ) u_var (
                .body(cap_q.img[IB-1:CODE_BITS]),
                .line(var_line[v])
            );
        end
    end

    // Next-state logic for both stages.
    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = in_valid;
        if (in_valid) cap_d.img = in_data;

        res_d      = res_q;
        res_d.vld  = 1'b0;
        res_d.pass = 1'b0;
        if (cap_q.vld) begin
            if (code_q == ALG_PATTERN) begin
                res_d.pass = 1'b1;
            end else begin
                res_d.vld  = 1'b1;
                res_d.line = var_line[code_q];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            res_q <= '0;
        end else begin
            cap_q <= cap_d;
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign fpc_pass  = res_q.pass;
    assign out_line  = res_q.line;

endmodule

// File: rtl/bdl_checker.sv
module bdl_checker (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [2:0]                    in_code,
    input logic                          out_valid,
    input logic                          fpc_pass,
    input logic [bdl_pkg::LINE_BITS-1:0] out_line
);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_code != 3'd0) |=> ##1 out_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid, 2) && $past(in_code, 2) != 3'd0));

    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_code == 3'd0) |=> ##1 (fpc_pass && !out_valid));

    p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && fpc_pass));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_line));
endmodule

bind base_delta_decomp bdl_checker u_bdl_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_code  (in_data[2:0]),
    .out_valid(out_valid),
    .fpc_pass (fpc_pass),
    .out_line (out_line)
);

// File: tb/base_delta_decomp_tb_top.sv
module base_delta_decomp_tb_top;
    localparam int IB = bdl_pkg::IMG_BITS;
    localparam int LB = bdl_pkg::LINE_BITS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [IB-1:0] in_data = '0;
    logic          out_valid;
    logic [LB-1:0] out_line;
    logic          fpc_pass;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Expected pipeline: kind 0 idle, 1 line, 2 pass-through.
    int            e1_kind = 0, e2_kind = 0;
    logic [LB-1:0] e1_line = '0, e2_line = '0;
    string         e1_tag = "R9", e2_tag = "R9";
    logic [LB-1:0] last_line = '0;

    logic [31:0] dl [32];

    always #5 clk = ~clk;

    base_delta_decomp dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_line(out_line), .fpc_pass(fpc_pass)
    );

    function automatic int tb_bb(input int c);
        if (c == 7) return 2;
        if (c == 5 || c == 6) return 4;
        return 8;
    endfunction

    function automatic int tb_db(input int c);
        case (c)
            2, 5, 7: return 1;
            3, 6:    return 2;
            4:       return 4;
            default: return 0;
        endcase
    endfunction

    task automatic build(input int code, input logic [63:0] base, input logic [31:0] mask,
                         output logic [IB-1:0] img, output logic [LB-1:0] line);
        int bb, db, nw, pos;
        logic [63:0] wmask, dmask, dv, sx, val;
        bb = tb_bb(code); db = tb_db(code); nw = 64 / bb;
        for (int i = 0; i < IB; i += 32) begin
            logic [31:0] r;
            r = $urandom;
            for (int k = 0; k < 32; k++) if (i + k < IB) img[i+k] = r[k];
        end
        img[2:0] = code[2:0];
        pos = 3;
        for (int w = 0; w < nw; w++) img[pos+w] = mask[w];
        pos += nw;
        for (int i = 0; i < bb*8; i++) img[pos+i] = base[i];
        pos += bb*8;
        wmask = (bb == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (bb*8)) - 64'd1);
        dmask = (64'd1 << (db*8)) - 64'd1;
        line = '0;
        for (int w = 0; w < nw; w++) begin
            dv = {32'd0, dl[w]} & dmask;
            for (int i = 0; i < db*8; i++) img[pos + w*db*8 + i] = dv[i];
            if (db == 0) sx = 64'd0;
            else if (dv[db*8-1]) sx = dv | ~dmask;
            else sx = dv;
            val = ((mask[w] ? base : 64'd0) + sx) & wmask;
            for (int i = 0; i < bb*8; i++) line[w*bb*8 + i] = val[i];
        end
    endtask

    task automatic check_due();
        bit ok;
        n_cmp++;
        if (e2_kind == 1) begin
            ok = out_valid && !fpc_pass && (out_line == e2_line);
            last_line = e2_line;
        end else if (e2_kind == 2) begin
            ok = fpc_pass && !out_valid && (out_line == last_line);
        end else begin
            ok = !out_valid && !fpc_pass && (out_line == last_line);
        end
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: valid=%0b pass=%0b line=%h expected kind=%0d line=%h",
                     e2_tag, out_valid, fpc_pass, out_line, e2_kind,
                     (e2_kind == 1) ? e2_line : last_line);
        end
    endtask

    task automatic step(input logic v, input logic [IB-1:0] d, input int kind,
                        input logic [LB-1:0] el, input string tag);
        @(negedge clk);
        check_due();
        e2_kind = e1_kind; e2_line = e1_line; e2_tag = e1_tag;
        e1_kind = kind;    e1_line = el;      e1_tag = tag;
        in_valid = v;
        in_data  = d;
    endtask

    task automatic run_pattern(input int code, input int mode, input string tag);
        logic [IB-1:0] img;
        logic [LB-1:0] line;
        logic [63:0]   base;
        logic [31:0]   mask;
        int db;
        db = tb_db(code);
        base = {$urandom, $urandom};
        mask = $urandom;
        for (int w = 0; w < 32; w++) dl[w] = $urandom;
        case (mode)
            1: begin mask = '1; for (int w = 0; w < 32; w++) dl[w] = (db == 0) ? 0 : ((32'd1 << (db*8-1)) - 1); end
            2: begin mask = '1; base = '0; for (int w = 0; w < 32; w++) dl[w] = (db == 0) ? 0 : (32'd1 << (db*8-1)); end
            3: mask = '0;
            4: begin mask = '1; base = '1; for (int w = 0; w < 32; w++) dl[w] = 32'd1; end
            default: ;
        endcase
        build(code, base, mask, img, line);
        step(1'b1, img, 1, line, tag);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0 || fpc_pass !== 1'b0 || out_line !== '0) begin
            n_bad++;
            $display("FAIL R1: valid=%b pass=%b line=%h expected 0 0 0", out_valid, fpc_pass, out_line);
        end
        rst_n = 1'b1;
        step(1'b0, '0, 0, '0, "R1");
        step(1'b0, '0, 0, '0, "R1");

        for (int code = 1; code < 8; code++) begin
            for (int mode = 0; mode < 12; mode++) begin
                string tag;
                if (code == 1)      tag = "R7";
                else if (mode == 3) tag = "R6";
                else if (mode == 1 || mode == 2 || mode == 4) tag = "R5";
                else if (mode == 5) tag = "R2";
                else if (mode == 6) tag = "R10";
                else if (mode == 7) tag = "R4";
                else if (mode == 8) tag = "R8";
                else                tag = "R11";
                run_pattern(code, mode, tag);
            end
            // Pass-through code followed by an idle gap.
            step(1'b1, {$urandom, $urandom, 3'd0}, 2, '0, "R3");
            step(1'b0, {$urandom, 3'd1}, 0, '0, "R9");
        end

        // Mixed stream: all codes interleaved with pass-through and gaps.
        for (int i = 0; i < 60; i++) begin
            int c;
            c = i % 9;
            if (c == 8)      step(1'b0, {$urandom, 3'd2}, 0, '0, "R9");
            else if (c == 0) step(1'b1, {$urandom, 3'd0}, 2, '0, "R3");
            else             run_pattern(c, 5 + (i % 7), "R10");
        end

        repeat (3) step(1'b0, '0, 0, '0, "R9");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule